// File: doc/BRIEF.md
# Inter-Core Interrupt Trigger Registers

This block is a small register bank on a shared bus. Any master can use it to interrupt one of several processor cores and to leave a note of who asked. Each core owns two word-aligned registers. The first is a raise register, which sets source flags and can fire the core's interrupt. The second is a clear register, which the core writes to acknowledge source flags once it has serviced them. Both registers read back the same 28 sticky source flags in bits 31:4.

An interrupt is requested by writing bit 0 of a core's raise register as 1. The block answers with a single-cycle pulse on that core's `irq` line. One write can both set source flags and fire the pulse. The flags are already readable in the cycle the pulse appears, so an interrupt handler always finds them set.

The address map uses byte addresses. Raise registers sit at 0x00, 0x04 and 0x08 for cores 0, 1 and 2. Clear registers sit at 0x10, 0x14 and 0x18. The bus port is single-cycle: a write takes effect on the clock edge where `wr_en` is high, and `rdata` shows the register at `addr` combinationally.

Top module: `ipi_gen_regs`

## Requirements
- R1: After reset, every source flag is 0, every `irq` line is 0, and every address reads 0.
- R2: A write to raise register k sets each flag of core k whose bit in `wdata[31:4]` is 1. Flags whose bit is 0 keep their value, and no flag of core k ever clears except through its clear register.
- R3: Reading raise register k or clear register k returns core k's flags in bits 31:4. Bits 3:0 always read 0.
- R4: A write with `wdata[0]`=1 to raise register k (address 4k) drives `irq[k]` high for exactly the one cycle after the write edge. No other `irq` line goes high.
- R5: A raise-register write with `wdata[0]`=0 produces no pulse. Bits 3:1 of a write store nothing and cause nothing.
- R6: A write to clear register k (address 0x10+4k) clears each flag of core k whose bit in `wdata[31:4]` is 1 and leaves the rest unchanged. It never produces a pulse, whatever its bit 0 holds.
- R7: When one write both sets flags and fires the trigger, the new flags are readable in the same cycle as the pulse.
- R8: Every other address returns 0 on reads and changes no flag and no pulse on writes. This covers 0x0C, 0x1C, any address that is not word-aligned, and anything at or above 0x20.
- R9: Trigger writes on consecutive cycles produce pulses on consecutive cycles, one for each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; the write takes effect at the rising edge |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 3 | One-cycle interrupt pulse per core |

## Verification
A corrupt flag shows up on the first read of either register belonging to that core, and again in the handler of the next interrupt. A lost or stuck pulse shows up on `irq` in the cycle after the trigger write. Because the bench compares every `irq` line and the read data at the current address on every clock, a divergence appears within one cycle of its cause. Flag state is read back after each set, clear and unmapped write, so a write that leaks into the wrong core is visible immediately.

// File: rtl/ipi_gen_regs.sv
module ipi_gen_regs #(
  parameter int NUM_CORES = 3,
  parameter int SRC_BITS  = 28,
  parameter int ADDR_W    = 8,
  localparam int DW       = SRC_BITS + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic [NUM_CORES-1:0] irq
);
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int ACK_BASE = 1 << IDX_W;
  localparam int WW       = ADDR_W - 2;

  logic [WW-1:0]                 word;
  logic                          aligned;
  logic [NUM_CORES-1:0]          gen_hit, ack_hit;
  logic [NUM_CORES*SRC_BITS-1:0] flags_flat;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    logic [SRC_BITS-1:0] fl;
    assign gen_hit[k] = aligned && (word == WW'(k));
    assign ack_hit[k] = aligned && (word == WW'(ACK_BASE + k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fl     <= '0;
        irq[k] <= 1'b0;
      end else begin
        irq[k] <= wr_en && gen_hit[k] && wdata[0];
        if (wr_en && gen_hit[k])      fl <= fl | wdata[DW-1:4];
        else if (wr_en && ack_hit[k]) fl <= fl & ~wdata[DW-1:4];
      end
    end

    assign flags_flat[k*SRC_BITS +: SRC_BITS] = fl;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_CORES; k++)
      if (gen_hit[k] || ack_hit[k])
        rdata = {flags_flat[k*SRC_BITS +: SRC_BITS], 4'b0000};
  end
endmodule

module ipi_gen_regs_chk #(
  parameter int NUM_CORES = 3,
  parameter int SRC_BITS  = 28,
  parameter int ADDR_W    = 8,
  localparam int DW       = SRC_BITS + 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             addr,
  input logic [DW-1:0]                 wdata,
  input logic [DW-1:0]                 rdata,
  input logic [NUM_CORES-1:0]          irq,
  input logic [NUM_CORES*SRC_BITS-1:0] flags_flat
);
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int ACK_BASE = 1 << IDX_W;

  int unsigned a_int;
  logic mapped, in_ack;
  assign a_int  = int'(addr);
  assign mapped = (addr[1:0] == 2'b00) &&
                  ((a_int < 4*NUM_CORES) ||
                   (a_int >= 4*ACK_BASE && a_int < 4*(ACK_BASE+NUM_CORES)));
  assign in_ack = a_int >= 4*ACK_BASE;

  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq));

  // R5
  no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[0]) |=> (irq == '0));

  // R6
  ack_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_ack) |=> (irq == '0));

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> ($stable(flags_flat) && irq == '0));

  // R3
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) rdata[3:0] == 4'b0000);

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_k
    // R4
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[k] |-> ($past(wr_en) && $past(wdata[0]) && $past(a_int) == 4*k));
    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(wr_en) && $past(a_int) == 4*(ACK_BASE+k)) |->
      (($past(flags_flat[k*SRC_BITS +: SRC_BITS]) & ~flags_flat[k*SRC_BITS +: SRC_BITS]) == '0));
  end
endmodule

bind ipi_gen_regs ipi_gen_regs_chk #(
  .NUM_CORES(NUM_CORES), .SRC_BITS(SRC_BITS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq(irq), .flags_flat(flags_flat)
);

// File: tb/tb_ipi_gen_regs.sv
`timescale 1ns/1ps
module tb_ipi_gen_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  int total = 0, bad = 0;
  logic [27:0] mf [3];
  logic [2:0]  mirq;

  always #2.5 clk = ~clk;

  ipi_gen_regs dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [31:0] mread(logic [7:0] a);
    if (a[1:0] != 0) return 32'h0;
    if (a < 8'h0C)                 return {mf[a/4], 4'h0};
    if (a >= 8'h10 && a < 8'h1C)   return {mf[(a-8'h10)/4], 4'h0};
    return 32'h0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive, compare outputs with the model, then advance the model
  task automatic cyc(string tag, logic w, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
    #0.5;
    chk(tag, "rdata", rdata, mread(a));
    chk(tag, "irq", {29'b0, irq}, {29'b0, mirq});
    mirq = 3'b000;
    if (w && a[1:0] == 0) begin
      if (a < 8'h0C) begin
        mf[a/4] = mf[a/4] | d[31:4];
        mirq[a/4] = d[0];
      end else if (a >= 8'h10 && a < 8'h1C) begin
        mf[(a-8'h10)/4] = mf[(a-8'h10)/4] & ~d[31:4];
      end
    end
  endtask

  task automatic rd(string tag, logic [7:0] a);
    cyc(tag, 1'b0, a, 32'hDEAD_BEEF);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) mf[i] = '0;
    mirq = '0;
    #12 rst_n = 1;
    // R1 reset state on all addresses
    for (int a = 0; a < 32; a += 4) rd("R1", 8'(a));
    // R7 / R4 combined set and trigger on core 0
    cyc("R7", 1, 8'h00, 32'h0000_00F1);
    rd("R7", 8'h00);
    rd("R3", 8'h10);
    // R5 set without trigger, reserved bits only
    cyc("R5", 1, 8'h04, 32'h8000_0000);
    cyc("R5", 1, 8'h04, 32'h0000_000E);
    rd("R5", 8'h04);
    // R2 write of zeros leaves flags unchanged, set accumulates
    cyc("R2", 1, 8'h00, 32'h0000_0000);
    cyc("R2", 1, 8'h00, 32'h1230_0000);
    rd("R2", 8'h00);
    // R4 single pulse on core 2, R9 back to back
    cyc("R4", 1, 8'h08, 32'h0000_0001);
    rd("R4", 8'h08);
    rd("R4", 8'h08);
    cyc("R9", 1, 8'h08, 32'h0000_0001);
    cyc("R9", 1, 8'h08, 32'h0000_0011);
    cyc("R9", 1, 8'h04, 32'h0000_0001);
    rd("R9", 8'h08);
    rd("R9", 8'h08);
    // R6 clear through acknowledge register; bit 0 set must not pulse
    cyc("R6", 1, 8'h10, 32'h0000_0031);
    rd("R6", 8'h00);
    cyc("R6", 1, 8'h14, 32'hFFFF_FFFF);
    rd("R6", 8'h04);
    rd("R6", 8'h00);
    // R8 unmapped addresses
    cyc("R8", 1, 8'h0C, 32'hFFFF_FFFF);
    cyc("R8", 1, 8'h1C, 32'hFFFF_FFFF);
    cyc("R8", 1, 8'h01, 32'hFFFF_FFF1);
    cyc("R8", 1, 8'h12, 32'hFFFF_FFFF);
    cyc("R8", 1, 8'h20, 32'hFFFF_FFF1);
    cyc("R8", 1, 8'hFC, 32'hFFFF_FFF1);
    for (int a = 0; a < 32; a += 4) rd("R8", 8'(a));
    rd("R8", 8'h02);
    rd("R8", 8'h40);
    // R3 all cores full pattern, read through both registers
    for (int k = 0; k < 3; k++) cyc("R3", 1, 8'(4*k), 32'hA5A5_A5A0 ^ (32'(k) << 8));
    for (int k = 0; k < 3; k++) begin
      rd("R3", 8'(4*k));
      rd("R3", 8'(16 + 4*k));
    end
    rd("R3", 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule